// File: doc/BRIEF.md
# Opcode-Driven Parameter Register Plug-in

This block is a control-plane slave that sits inside a packet-processing module and holds the configuration used by an address-lookup datapath: a root node pointer, two flow addresses and a control-cell channel identifier. Control cells arrive one 32-bit word per beat. They have already been filtered by module identifier. The block decodes the opcode in the header word and loads one or two registers from fixed bit fields of the payload words.

After a register update commits, the block sends back a response cell of the same length. The response carries the request opcode plus one, and each new value sits at the word and bit position it was taken from. The register values are also driven in parallel toward the lookup engine.

A cell is one header word (word 0) followed by twelve payload words (words 1 to 12). Both directions use a valid/ready handshake, and the final word of a cell is marked with a last flag.

Top module: `opcode_param_plugin`

## Requirements
- R1: After reset, all four registers read zero, `out_valid` is low and `in_ready` is high.
- R2: Opcode 0x10 (header word bits 31:24) loads the 19-bit root pointer from payload word 1, bits 31:13.
- R3: Opcode 0x12 loads flow address A from payload word 2, bits 31:16, and leaves flow B unchanged.
- R4: Opcode 0x14 loads flow address B from payload word 2, bits 15:0, and leaves flow A unchanged.
- R5: Opcode 0x16 loads flow A from word 2 bits 31:16 and flow B from word 2 bits 15:0, both from one cell.
- R6: Opcode 0x18 loads the 16-bit channel identifier from payload word 3, bits 31:16.
- R7: A register keeps its value until the clock edge that accepts the last word of a cell carrying a known opcode. The new value is visible on the outputs right after that edge.
- R8: After each update the block emits a 13-word response. The layout is as follows:
  - Word 0 holds the request opcode plus one in bits 31:24.
  - Each updated value sits at the word and bit range it was read from.
  - Every other bit is zero.
  - `out_last` is set on word 12 only.
- R9: A cell with any other opcode changes no register and produces no response.
- R10: `in_ready` is low while a response is pending. A response word is held stable while `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept an input word |
| in_data | input | 32 | Input cell word |
| in_last | input | 1 | Marks the last word of an input cell |
| out_valid | output | 1 | Response word valid |
| out_ready | input | 1 | Downstream accepts the response word |
| out_data | output | 32 | Response cell word |
| out_last | output | 1 | Marks the last word of a response |
| root_ptr | output | 19 | Root node pointer register |
| flow_a | output | 16 | Flow address A register |
| flow_b | output | 16 | Flow address B register |
| ctrl_chan | output | 16 | Control-cell channel identifier register |

## Verification
Some properties are checked by the embedded assertions on every cycle:
- registers hold between cell ends;
- an unknown opcode stays silent;
- response words stay frozen under back-pressure;
- a response is never followed by a stray word;
- a root-pointer load takes the right field.

Other behaviour shows up only in the bench's scenarios, where a scoreboard compares every response word against a model: the exact field placement for each opcode, the zero fill, the reply opcode, the last-word marking, and back-to-back cells stalled behind a pending response.

// File: rtl/opcode_param_plugin.sv
module opcode_param_plugin #(
  parameter int CELL_WORDS = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_last,
  output logic [18:0] root_ptr,
  output logic [15:0] flow_a,
  output logic [15:0] flow_b,
  output logic [15:0] ctrl_chan
);
  localparam int IW = $clog2(CELL_WORDS);
  localparam logic [IW-1:0] LAST_IDX = IW'(CELL_WORDS - 1);

  logic [IW-1:0] in_idx, out_idx;
  logic [7:0]    op_q, rsp_op;
  logic [31:0]   w1_q, w2_q, w3_q;
  logic          busy;

  wire        in_fire = in_valid && in_ready;
  wire        end_fire = in_fire && in_last;
  wire [7:0]  op_n = (in_idx == '0) ? in_data[31:24] : op_q;
  wire [31:0] w1_n = (in_idx == IW'(1)) ? in_data : w1_q;
  wire [31:0] w2_n = (in_idx == IW'(2)) ? in_data : w2_q;
  wire [31:0] w3_n = (in_idx == IW'(3)) ? in_data : w3_q;
  wire        known = (op_n == 8'h10) || (op_n == 8'h12) || (op_n == 8'h14) ||
                      (op_n == 8'h16) || (op_n == 8'h18);

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign out_last  = busy && (out_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_idx <= '0;
      op_q <= '0; w1_q <= '0; w2_q <= '0; w3_q <= '0;
    end else if (in_fire) begin
      if (in_last) in_idx <= '0;
      else if (in_idx != LAST_IDX) in_idx <= in_idx + 1'b1;
      if (in_idx == '0) begin
        op_q <= in_data[31:24];
        w1_q <= '0; w2_q <= '0; w3_q <= '0;
      end
      if (in_idx == IW'(1)) w1_q <= in_data;
      if (in_idx == IW'(2)) w2_q <= in_data;
      if (in_idx == IW'(3)) w3_q <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      root_ptr <= '0; flow_a <= '0; flow_b <= '0; ctrl_chan <= '0;
    end else if (end_fire) begin
      if (op_n == 8'h10) root_ptr <= w1_n[31:13];
      if (op_n == 8'h12 || op_n == 8'h16) flow_a <= w2_n[31:16];
      if (op_n == 8'h14 || op_n == 8'h16) flow_b <= w2_n[15:0];
      if (op_n == 8'h18) ctrl_chan <= w3_n[31:16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; out_idx <= '0; rsp_op <= '0;
    end else if (end_fire && known) begin
      busy <= 1'b1; out_idx <= '0; rsp_op <= op_n + 8'h01;
    end else if (busy && out_ready) begin
      if (out_idx == LAST_IDX) busy <= 1'b0;
      else out_idx <= out_idx + 1'b1;
    end
  end

  always_comb begin
    out_data = '0;
    if (busy) begin
      case (out_idx)
        IW'(0): out_data = {rsp_op, 24'h0};
        IW'(1): if (rsp_op == 8'h11) out_data = {root_ptr, 13'h0};
        IW'(2): begin
          if (rsp_op == 8'h13 || rsp_op == 8'h17) out_data[31:16] = flow_a;
          if (rsp_op == 8'h15 || rsp_op == 8'h17) out_data[15:0]  = flow_b;
        end
        IW'(3): if (rsp_op == 8'h19) out_data = {ctrl_chan, 16'h0};
        default: out_data = '0;
      endcase
    end
  end

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !end_fire |=> $stable(root_ptr) && $stable(flow_a) && $stable(flow_b) && $stable(ctrl_chan)); // R7
  AST_UNKNOWN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (end_fire && !known) |=> !out_valid); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last)); // R10
  AST_SINGLE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid); // R8
  AST_ROOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (end_fire && op_n == 8'h10) |=> root_ptr == $past(w1_n[31:13])); // R2
endmodule

// File: tb/test_opcode_param_plugin.sv
module test_opcode_param_plugin;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic [31:0] out_data;
  logic [18:0] root_ptr;
  logic [15:0] flow_a, flow_b, ctrl_chan;

  always #4 clk = ~clk;

  opcode_param_plugin i_opcode_param_plugin (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .root_ptr(root_ptr), .flow_a(flow_a), .flow_b(flow_b), .ctrl_chan(ctrl_chan));

  int checks = 0, fails = 0;
  logic [32:0] exp_q[$];
  logic [18:0] m_root = '0;
  logic [15:0] m_fa = '0, m_fb = '0, m_ch = '0;
  bit finished = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk(req, {root_ptr, flow_a, flow_b, ctrl_chan}, {m_root, m_fa, m_fb, m_ch});
  endtask

  task automatic send_cell(input logic [7:0] op, input logic [31:0] w1,
                           input logic [31:0] w2, input logic [31:0] w3, input string req);
    logic known;
    logic [31:0] w;
    known = (op == 8'h10) || (op == 8'h12) || (op == 8'h14) || (op == 8'h16) || (op == 8'h18);
    for (int i = 0; i < 13; i++) begin
      w = (i == 0) ? {op, 24'hA5C3E1} : (i == 1) ? w1 : (i == 2) ? w2 : (i == 3) ? w3 : 32'hDEAD0000 + i;
      in_valid = 1'b1; in_data = w; in_last = (i == 12);
      while (!in_ready) @(negedge clk);
      if (i == 12) chk({req, " R7 hold before last"}, {root_ptr, flow_a, flow_b, ctrl_chan}, {m_root, m_fa, m_fb, m_ch});
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    if (op == 8'h10) m_root = w1[31:13];
    if (op == 8'h12 || op == 8'h16) m_fa = w2[31:16];
    if (op == 8'h14 || op == 8'h16) m_fb = w2[15:0];
    if (op == 8'h18) m_ch = w3[31:16];
    chk_regs({req, " R7 update"});
    if (known) begin
      chk({req, " R10 stall"}, {63'h0, in_ready}, 64'h0);
      exp_q.push_back({1'b0, op + 8'h01, 24'h0});
      exp_q.push_back({1'b0, (op == 8'h10) ? {m_root, 13'h0} : 32'h0});
      exp_q.push_back({1'b0, (op == 8'h12 || op == 8'h16) ? m_fa : 16'h0,
                             (op == 8'h14 || op == 8'h16) ? m_fb : 16'h0});
      exp_q.push_back({1'b0, (op == 8'h18) ? {m_ch, 16'h0} : 32'h0});
      for (int i = 4; i < 13; i++) exp_q.push_back({(i == 12), 32'h0});
    end else begin
      chk({req, " R9 no response"}, {63'h0, out_valid}, 64'h0);
    end
  endtask

  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished) begin
      out_ready = (cyc % 3) != 0;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk("R8 unexpected word", {31'h0, out_last, out_data}, 64'hFFFF_FFFF_FFFF_FFFF);
        else begin
          logic [32:0] e;
          e = exp_q.pop_front();
          chk("R8 response word", {31'h0, out_last, out_data}, {31'h0, e});
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset regs", {root_ptr, flow_a, flow_b, ctrl_chan}, 64'h0);
    chk("R1 reset handshake", {62'h0, out_valid, in_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    send_cell(8'h10, 32'hFFFF_E123, 32'h1234_5678, 32'h9ABC_DEF0, "R2");
    send_cell(8'h12, 32'h0, 32'hBEEF_1111, 32'h0, "R3");
    send_cell(8'h14, 32'h0, 32'h2222_CAFE, 32'h0, "R4");
    send_cell(8'h16, 32'h0, 32'h0F0F_F0F0, 32'h0, "R5");
    send_cell(8'h18, 32'h0, 32'h0, 32'h7A5C_FFFF, "R6");
    send_cell(8'h11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 op11");
    send_cell(8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 op00");
    send_cell(8'h10, 32'h0000_2000, 32'h0, 32'h0, "R2 min");
    send_cell(8'h16, 32'h0, 32'hFFFF_0001, 32'h0, "R5 again");
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R8 idle after responses", {62'h0, out_valid, in_ready}, 64'h1);
    chk_regs("R9 final regs");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule